// File: doc/BRIEF.md
# Ticket-locked software FIFO DMA channel

This block is a single bus-master channel that moves an endless stream of words between a coprocessor FIFO port and a circular buffer in shared memory. Other agents can reach the same buffer. Each pass of the channel takes a ticket lock with an atomic compare-and-swap and waits until the lock serves its ticket. It then reads the buffer's three-word status, moves as many words as fit in one burst, writes the status back and releases the lock. The direction bit selects the role. As producer the channel pops words from the coprocessor and writes them to memory. As consumer it reads words from memory and pushes them to the coprocessor.

Software programs a small register file: the direction, the buffer base, the buffer size, the status descriptor address, the lock address and a running flag. A non-zero write to the running flag starts the loop. A zero write stops it at the end of the current pass. A bus error stops the channel in an error state with the interrupt raised, until the running flag is cleared. All bus addresses count words.

Top module: `sfc_chan`

## Requirements
- R1: After reset the channel is idle: `req_valid_o` and `irq_o` are low and no coprocessor pop or push occurs.
- R2: Register offsets on `cfg_addr_i` are 0 direction (bit 0, 1 = producer), 1 buffer base, 2 buffer size in words, 3 descriptor address, 4 lock address and 5 running. The channel issues no request until a non-zero value is written to offset 5.
- R3: Command codes are read 0, write 1 and compare-and-swap 2. A pass issues, in order: a 1-word read of lock+1 (the ticket), a compare-and-swap at lock+1, a 1-word read of lock, a 3-word read of the descriptor, the data burst, a 3-beat write of the descriptor, and a 1-word write of lock.
- R4: The compare-and-swap expects the ticket that was read and stores ticket+1. If the returned old value differs from the ticket, the channel restarts at the ticket read.
- R5: While the value read at lock differs from the held ticket, the channel re-reads lock and touches neither the descriptor nor the buffer.
- R6: Descriptor word 0 is the read index, word 1 is the write index and word 2 is the item count. They are written back in that order.
- R7: The burst length N is the minimum of `cop_level_i`, the buffer space (size-count as producer, count as consumer) and size minus the moving index. When N is 0 the channel skips the data and descriptor steps and goes straight to the lock release.
- R8: As producer the channel writes N popped words, in pop order, to base+write index onward. The write index then advances by N modulo size and the count grows by N.
- R9: As consumer the channel reads N words from base+read index and pushes them to the coprocessor in address order. The read index then advances by N modulo size and the count drops by N.
- R10: The release writes ticket+1 to lock. The loop repeats while running is set. If running is clear at the release response, the channel returns to idle.
- R11: An error on any response moves the channel to an error state. There `irq_o` is high and no request is issued. The channel leaves the state only when running is written to 0, which lowers `irq_o` and returns it to idle.
- R12: A request that is not accepted keeps `req_valid_o`, `req_addr_o` and `req_cmd_o` unchanged until `req_ready_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register offset |
| cfg_wdata_i | input | DW | Register write data |
| req_valid_o | output | 1 | Bus request valid |
| req_ready_i | input | 1 | Bus request accepted |
| req_cmd_o | output | 2 | Command: 0 read, 1 write, 2 compare-and-swap |
| req_addr_o | output | DW | Word address of this beat (burst start for reads) |
| req_wdata_o | output | DW | Write data, or new value for compare-and-swap |
| req_cmp_o | output | DW | Expected value for compare-and-swap |
| req_len_o | output | LW | Burst length in words |
| req_last_o | output | 1 | Last beat of the request |
| rsp_valid_i | input | 1 | Response beat valid |
| rsp_data_i | input | DW | Read data, or old value after compare-and-swap |
| rsp_err_i | input | 1 | Response carries a bus error |
| cop_level_i | input | LW | Words the coprocessor can supply (producer) or accept (consumer) |
| cop_rdata_i | input | DW | Head word of the coprocessor output FIFO |
| cop_pop_o | output | 1 | Pop the coprocessor output FIFO |
| cop_wdata_o | output | DW | Word pushed to the coprocessor |
| cop_push_o | output | 1 | Push into the coprocessor input FIFO |
| irq_o | output | 1 | Error interrupt |

## Verification
The bench builds the channel with its default 32-bit data and 16-bit level widths. It uses buffers of 8 and 16 words and coprocessor levels up to 10, so each limit of R7 can be made the binding one in a single pass. Buffer full and empty are reached this way, and a multi-pass stream wraps the buffer within a few passes. The memory model stalls one request cycle in three and lets the bench place lock and ticket values, steal a ticket inside a compare-and-swap and fail a chosen address. With these controls, lock contention, the swap retry and the error path can be reached directly.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [1:0] {
    CMD_RD  = 2'd0,
    CMD_WR  = 2'd1,
    CMD_CAS = 2'd2
  } bus_cmd_e;

  typedef enum logic [4:0] {
    S_IDLE,
    S_TK_REQ,  S_TK_RSP,
    S_CAS_REQ, S_CAS_RSP,
    S_LK_REQ,  S_LK_RSP,
    S_ST_REQ,  S_ST_RSP,
    S_CALC,
    S_DAT_REQ, S_DAT_RSP,
    S_SW_REQ,  S_SW_RSP,
    S_REL_REQ, S_REL_RSP,
    S_ERR
  } seq_st_e;

  localparam logic [2:0] REG_DIR  = 3'd0;
  localparam logic [2:0] REG_BASE = 3'd1;
  localparam logic [2:0] REG_SIZE = 3'd2;
  localparam logic [2:0] REG_DESC = 3'd3;
  localparam logic [2:0] REG_LOCK = 3'd4;
  localparam logic [2:0] REG_RUN  = 3'd5;

  localparam int unsigned STATUS_WORDS = 3;

endpackage

// File: rtl/sfc_regs.sv
module sfc_regs
  import sfc_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [2:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          dir_o,
  output logic [DW-1:0] base_o,
  output logic [DW-1:0] size_o,
  output logic [DW-1:0] desc_o,
  output logic [DW-1:0] lock_o,
  output logic          run_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o  <= 1'b0;
      base_o <= '0;
      size_o <= '0;
      desc_o <= '0;
      lock_o <= '0;
      run_o  <= 1'b0;
    end else if (we_i) begin
      unique case (addr_i)
        REG_DIR:  dir_o  <= wdata_i[0];
        REG_BASE: base_o <= wdata_i;
        REG_SIZE: size_o <= wdata_i;
        REG_DESC: desc_o <= wdata_i;
        REG_LOCK: lock_o <= wdata_i;
        REG_RUN:  run_o  <= (wdata_i != '0);
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sfc_burst.sv
module sfc_burst #(
  parameter int unsigned DW = 32,
  parameter int unsigned LW = 16
) (
  input  logic          dir_i,
  input  logic [DW-1:0] size_i,
  input  logic [DW-1:0] rd_idx_i,
  input  logic [DW-1:0] wr_idx_i,
  input  logic [DW-1:0] cnt_i,
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] n_i,
  output logic [LW-1:0] n_o,
  output logic [DW-1:0] nxt_idx_o,
  output logic [DW-1:0] nxt_cnt_o
);

  logic [DW-1:0] idx, room, to_wrap, lvl_ext, m1, m2, n_ext, sum;

  assign idx     = dir_i ? wr_idx_i : rd_idx_i;
  assign lvl_ext = DW'(level_i);

  always_comb begin
    if (dir_i) room = (cnt_i >= size_i) ? '0 : size_i - cnt_i;
    else       room = cnt_i;
    to_wrap = (idx >= size_i) ? '0 : size_i - idx;
    m1      = (room < to_wrap) ? room : to_wrap;
    m2      = (m1 < lvl_ext) ? m1 : lvl_ext;
  end

  assign n_o = m2[LW-1:0];

  // index advance uses the latched burst length
  assign n_ext     = DW'(n_i);
  assign sum       = idx + n_ext;
  assign nxt_idx_o = (sum >= size_i) ? sum - size_i : sum;
  assign nxt_cnt_o = dir_i ? cnt_i + n_ext : cnt_i - n_ext;

endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          dir_i,
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] desc_i,
  input  logic [DW-1:0] lock_i,
  input  logic [LW-1:0] n_calc_i,
  input  logic [DW-1:0] nxt_idx_i,
  input  logic [DW-1:0] nxt_cnt_i,
  output logic [DW-1:0] rd_idx_o,
  output logic [DW-1:0] wr_idx_o,
  output logic [DW-1:0] cnt_o,
  output logic [LW-1:0] n_o,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [1:0]    req_cmd_o,
  output logic [DW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  output logic [DW-1:0] req_cmp_o,
  output logic [LW-1:0] req_len_o,
  output logic          req_last_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic          rsp_err_i,
  input  logic [DW-1:0] cop_rdata_i,
  output logic          cop_pop_o,
  output logic [DW-1:0] cop_wdata_o,
  output logic          cop_push_o,
  output logic          irq_o
);

  seq_st_e       state_q, state_d;
  logic [DW-1:0] ticket_q, rd_q, wr_q, cnt_q;
  logic [LW-1:0] n_q, beat_q;
  logic          hs, rsp_ok, rsp_bad, wait_st, last_beat;

  assign hs        = req_valid_o && req_ready_i;
  assign rsp_ok    = rsp_valid_i && !rsp_err_i;
  assign last_beat = (beat_q == n_q - LW'(1));

  always_comb begin
    unique case (state_q)
      S_TK_RSP, S_CAS_RSP, S_LK_RSP, S_ST_RSP,
      S_DAT_RSP, S_SW_RSP, S_REL_RSP: wait_st = 1'b1;
      default:                        wait_st = 1'b0;
    endcase
  end
  assign rsp_bad = wait_st && rsp_valid_i && rsp_err_i;

  // request drive
  always_comb begin
    req_valid_o = 1'b0;
    req_cmd_o   = CMD_RD;
    req_addr_o  = '0;
    req_wdata_o = '0;
    req_cmp_o   = '0;
    req_len_o   = LW'(1);
    req_last_o  = 1'b1;
    unique case (state_q)
      S_TK_REQ: begin
        req_valid_o = 1'b1;
        req_addr_o  = lock_i + DW'(1);
      end
      S_CAS_REQ: begin
        req_valid_o = 1'b1;
        req_cmd_o   = CMD_CAS;
        req_addr_o  = lock_i + DW'(1);
        req_cmp_o   = ticket_q;
        req_wdata_o = ticket_q + DW'(1);
      end
      S_LK_REQ: begin
        req_valid_o = 1'b1;
        req_addr_o  = lock_i;
      end
      S_ST_REQ: begin
        req_valid_o = 1'b1;
        req_addr_o  = desc_i;
        req_len_o   = LW'(STATUS_WORDS);
      end
      S_DAT_REQ: begin
        req_valid_o = 1'b1;
        req_len_o   = n_q;
        if (dir_i) begin
          req_cmd_o   = CMD_WR;
          req_addr_o  = base_i + wr_q + DW'(beat_q);
          req_wdata_o = cop_rdata_i;
          req_last_o  = last_beat;
        end else begin
          req_addr_o  = base_i + rd_q;
        end
      end
      S_SW_REQ: begin
        req_valid_o = 1'b1;
        req_cmd_o   = CMD_WR;
        req_addr_o  = desc_i + DW'(beat_q);
        req_len_o   = LW'(STATUS_WORDS);
        req_last_o  = (beat_q == LW'(STATUS_WORDS - 1));
        unique case (beat_q[1:0])
          2'd0:    req_wdata_o = rd_q;
          2'd1:    req_wdata_o = wr_q;
          default: req_wdata_o = cnt_q;
        endcase
      end
      S_REL_REQ: begin
        req_valid_o = 1'b1;
        req_cmd_o   = CMD_WR;
        req_addr_o  = lock_i;
        req_wdata_o = ticket_q + DW'(1);
      end
      default: ;
    endcase
  end

  assign cop_pop_o   = (state_q == S_DAT_REQ) && dir_i && req_ready_i;
  assign cop_push_o  = (state_q == S_DAT_RSP) && !dir_i && rsp_ok;
  assign cop_wdata_o = rsp_data_i;
  assign irq_o       = (state_q == S_ERR);

  // next state
  always_comb begin
    state_d = state_q;
    if (rsp_bad) begin
      state_d = S_ERR;
    end else begin
      unique case (state_q)
        S_IDLE:    if (run_i) state_d = S_TK_REQ;
        S_TK_REQ:  if (hs) state_d = S_TK_RSP;
        S_TK_RSP:  if (rsp_ok) state_d = S_CAS_REQ;
        S_CAS_REQ: if (hs) state_d = S_CAS_RSP;
        S_CAS_RSP: if (rsp_ok) state_d = (rsp_data_i == ticket_q) ? S_LK_REQ : S_TK_REQ;
        S_LK_REQ:  if (hs) state_d = S_LK_RSP;
        S_LK_RSP:  if (rsp_ok) state_d = (rsp_data_i == ticket_q) ? S_ST_REQ : S_LK_REQ;
        S_ST_REQ:  if (hs) state_d = S_ST_RSP;
        S_ST_RSP:  if (rsp_ok && beat_q == LW'(STATUS_WORDS - 1)) state_d = S_CALC;
        S_CALC:    state_d = (n_calc_i == '0) ? S_REL_REQ : S_DAT_REQ;
        S_DAT_REQ: if (hs && (!dir_i || last_beat)) state_d = S_DAT_RSP;
        S_DAT_RSP: if (rsp_ok && (dir_i || last_beat)) state_d = S_SW_REQ;
        S_SW_REQ:  if (hs && req_last_o) state_d = S_SW_RSP;
        S_SW_RSP:  if (rsp_ok) state_d = S_REL_REQ;
        S_REL_REQ: if (hs) state_d = S_REL_RSP;
        S_REL_RSP: if (rsp_ok) state_d = run_i ? S_TK_REQ : S_IDLE;
        S_ERR:     if (!run_i) state_d = S_IDLE;
        default:   state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      ticket_q <= '0;
      rd_q     <= '0;
      wr_q     <= '0;
      cnt_q    <= '0;
      n_q      <= '0;
      beat_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_TK_RSP && rsp_ok) ticket_q <= rsp_data_i;
      if (state_q == S_LK_RSP) beat_q <= '0;
      if (state_q == S_ST_RSP && rsp_ok && !rsp_bad) begin
        unique case (beat_q[1:0])
          2'd0:    rd_q  <= rsp_data_i;
          2'd1:    wr_q  <= rsp_data_i;
          default: cnt_q <= rsp_data_i;
        endcase
        beat_q <= (beat_q == LW'(STATUS_WORDS - 1)) ? '0 : beat_q + LW'(1);
      end
      if (state_q == S_CALC) begin
        n_q    <= n_calc_i;
        beat_q <= '0;
      end
      if (state_q == S_DAT_REQ && hs && dir_i)
        beat_q <= last_beat ? '0 : beat_q + LW'(1);
      if (state_q == S_DAT_RSP && rsp_ok) begin
        if (!dir_i) beat_q <= last_beat ? '0 : beat_q + LW'(1);
        if (dir_i || last_beat) begin
          if (dir_i) wr_q <= nxt_idx_i;
          else       rd_q <= nxt_idx_i;
          cnt_q <= nxt_cnt_i;
        end
      end
      if (state_q == S_SW_REQ && hs)
        beat_q <= req_last_o ? '0 : beat_q + LW'(1);
    end
  end

  assign rd_idx_o = rd_q;
  assign wr_idx_o = wr_q;
  assign cnt_o    = cnt_q;
  assign n_o      = n_q;

  p_hold_req_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o) && $stable(req_cmd_o));

  p_err_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_st && rsp_valid_i && rsp_err_i |=> irq_o);

  p_err_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !req_valid_o && !cop_pop_o);

  p_stop_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_REL_RSP) && rsp_ok && !run_i |=> (state_q == S_IDLE) && !req_valid_o);

  p_spin_lock_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LK_RSP) && rsp_ok && (rsp_data_i != ticket_q) |=> (state_q == S_LK_REQ));

  p_cas_retry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CAS_RSP) && rsp_ok && (rsp_data_i != ticket_q) |=> (state_q == S_TK_REQ));

endmodule

// File: rtl/sfc_chan.sv
module sfc_chan
  import sfc_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [DW-1:0] cfg_wdata_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [1:0]    req_cmd_o,
  output logic [DW-1:0] req_addr_o,
  output logic [DW-1:0] req_wdata_o,
  output logic [DW-1:0] req_cmp_o,
  output logic [LW-1:0] req_len_o,
  output logic          req_last_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic          rsp_err_i,
  input  logic [LW-1:0] cop_level_i,
  input  logic [DW-1:0] cop_rdata_i,
  output logic          cop_pop_o,
  output logic [DW-1:0] cop_wdata_o,
  output logic          cop_push_o,
  output logic          irq_o
);

  logic          dir, run;
  logic [DW-1:0] base, size, desc, lock;
  logic [DW-1:0] rd_idx, wr_idx, cnt, nxt_idx, nxt_cnt;
  logic [LW-1:0] n_calc, n_held;

  sfc_regs #(.DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_wdata_i),
    .dir_o   (dir),
    .base_o  (base),
    .size_o  (size),
    .desc_o  (desc),
    .lock_o  (lock),
    .run_o   (run)
  );

  sfc_burst #(.DW(DW), .LW(LW)) u_burst (
    .dir_i     (dir),
    .size_i    (size),
    .rd_idx_i  (rd_idx),
    .wr_idx_i  (wr_idx),
    .cnt_i     (cnt),
    .level_i   (cop_level_i),
    .n_i       (n_held),
    .n_o       (n_calc),
    .nxt_idx_o (nxt_idx),
    .nxt_cnt_o (nxt_cnt)
  );

  sfc_seq #(.DW(DW), .LW(LW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .dir_i       (dir),
    .base_i      (base),
    .desc_i      (desc),
    .lock_i      (lock),
    .n_calc_i    (n_calc),
    .nxt_idx_i   (nxt_idx),
    .nxt_cnt_i   (nxt_cnt),
    .rd_idx_o    (rd_idx),
    .wr_idx_o    (wr_idx),
    .cnt_o       (cnt),
    .n_o         (n_held),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_cmd_o   (req_cmd_o),
    .req_addr_o  (req_addr_o),
    .req_wdata_o (req_wdata_o),
    .req_cmp_o   (req_cmp_o),
    .req_len_o   (req_len_o),
    .req_last_o  (req_last_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_data_i  (rsp_data_i),
    .rsp_err_i   (rsp_err_i),
    .cop_rdata_i (cop_rdata_i),
    .cop_pop_o   (cop_pop_o),
    .cop_wdata_o (cop_wdata_o),
    .cop_push_o  (cop_push_o),
    .irq_o       (irq_o)
  );

endmodule

// File: tb/tb_sfc_chan.sv
`timescale 1ns/1ps
module tb_sfc_chan;

  localparam int DW = 32;
  localparam int LW = 16;
  localparam logic [7:0] LOCK = 8'h10, TICK = 8'h11, DESC = 8'h20, BASE = 8'h40;

  // {dir, size, rd, wr, cnt, level, expected N}
  localparam logic [55:0] VEC [8] = '{
    {8'd1, 8'd8,  8'd0, 8'd0,  8'd0, 8'd5,  8'd5},
    {8'd1, 8'd8,  8'd2, 8'd6,  8'd4, 8'd5,  8'd2},
    {8'd0, 8'd8,  8'd6, 8'd2,  8'd4, 8'd5,  8'd2},
    {8'd0, 8'd8,  8'd1, 8'd5,  8'd4, 8'd3,  8'd3},
    {8'd1, 8'd8,  8'd3, 8'd3,  8'd8, 8'd4,  8'd0},
    {8'd0, 8'd8,  8'd0, 8'd0,  8'd0, 8'd4,  8'd0},
    {8'd1, 8'd8,  8'd0, 8'd0,  8'd0, 8'd0,  8'd0},
    {8'd0, 8'd16, 8'd4, 8'd12, 8'd8, 8'd10, 8'd8}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [2:0] cfg_addr_i = '0;
  logic [DW-1:0] cfg_wdata_i = '0;
  logic req_valid_o, req_ready_i = 1'b0, req_last_o;
  logic [1:0] req_cmd_o;
  logic [DW-1:0] req_addr_o, req_wdata_o, req_cmp_o;
  logic [LW-1:0] req_len_o;
  logic rsp_valid_i = 1'b0, rsp_err_i = 1'b0;
  logic [DW-1:0] rsp_data_i = '0;
  logic [LW-1:0] cop_level_i = '0;
  logic [DW-1:0] cop_rdata_i;
  logic cop_pop_o, cop_push_o, irq_o;
  logic [DW-1:0] cop_wdata_o;

  sfc_chan #(.DW(DW), .LW(LW)) dut (.*);

  always #10 clk_i = ~clk_i;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] q_data [64];
  logic          q_err [64];
  int q_wr = 0, q_rd = 0;
  logic [8:0] err_addr = 9'h1FF;
  bit cas_steal = 0, wr_err = 0;
  int cyc = 0, n_acc = 0, n_cas = 0, hold_viol = 0;
  bit log_on = 0;
  int log_n = 0;
  logic [1:0] log_cmd [64];
  logic [7:0] log_addr [64];
  logic [DW-1:0] src_val = 32'h5000;
  logic [DW-1:0] sink [64];
  int sink_n = 0;
  bit stall_prev = 0;
  logic [DW-1:0] pa;
  logic [1:0] pc;
  int n_chk = 0, n_fail = 0;

  assign cop_rdata_i = src_val;

  task automatic push_rsp(input logic [DW-1:0] d, input logic e);
    q_data[q_wr % 64] = d;
    q_err[q_wr % 64]  = e;
    q_wr++;
  endtask

  // behavioural memory, evaluated in the low half of the clock
  always begin
    @(negedge clk_i);
    cyc++;
    if (stall_prev && (!req_valid_o || req_addr_o != pa || req_cmd_o != pc)) hold_viol++;
    req_ready_i = rst_ni && (cyc % 3 != 0);
    if (q_rd != q_wr) begin
      rsp_valid_i = 1'b1;
      rsp_data_i  = q_data[q_rd % 64];
      rsp_err_i   = q_err[q_rd % 64];
      q_rd++;
    end else begin
      rsp_valid_i = 1'b0;
      rsp_err_i   = 1'b0;
    end
    #1;
    stall_prev = req_valid_o && !req_ready_i;
    pa = req_addr_o;
    pc = req_cmd_o;
    if (cop_push_o && sink_n < 64) begin
      sink[sink_n] = cop_wdata_o;
      sink_n++;
    end
    if (req_valid_o && req_ready_i) begin
      automatic logic [7:0] a = req_addr_o[7:0];
      n_acc++;
      if (log_on && log_n < 64) begin
        log_cmd[log_n] = req_cmd_o;
        log_addr[log_n] = a;
        log_n++;
      end
      case (req_cmd_o)
        2'd0: for (int i = 0; i < int'(req_len_o); i++)
                push_rsp(mem[8'(a + i)], {1'b0, 8'(a + i)} == err_addr);
        2'd1: begin
          if ({1'b0, a} == err_addr) wr_err = 1;
          else mem[a] = req_wdata_o;
          if (cop_pop_o) src_val++;
          if (req_last_o) begin
            push_rsp('0, wr_err);
            wr_err = 0;
          end
        end
        default: begin
          automatic logic [DW-1:0] old;
          n_cas++;
          if (cas_steal) begin
            mem[a] = mem[a] + 1;
            cas_steal = 0;
          end
          old = mem[a];
          if (old == req_cmp_o) mem[a] = req_wdata_o;
          push_rsp(old, 1'b0);
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
  endtask

  task automatic cfg(input logic [2:0] a, input logic [DW-1:0] d);
    @(posedge clk_i); #5;
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(posedge clk_i); #5;
    cfg_we_i = 1'b0;
  endtask

  task automatic one_pass();
    cfg(3'd5, 32'd1);
    cfg(3'd5, 32'd0);
    wait_cyc(300);
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000 + i;
    wait_cyc(3);
    #5 rst_ni = 1'b1;
    wait_cyc(2);
    #6;
    chk(!req_valid_o && !irq_o && !cop_pop_o && !cop_push_o, "R1 reset idle", {req_valid_o, irq_o}, 0);

    cfg(3'd1, BASE);
    cfg(3'd3, DESC);
    cfg(3'd4, LOCK);
    cfg(3'd0, 32'd1);
    wait_cyc(20);
    chk(n_acc == 0, "R2 no request before running", n_acc, 0);

    // burst table
    for (int v = 0; v < 8; v++) begin
      automatic logic [7:0] dir = VEC[v][55:48], sz = VEC[v][47:40];
      automatic logic [7:0] rd = VEC[v][39:32], wr = VEC[v][31:24];
      automatic logic [7:0] ct = VEC[v][23:16], lv = VEC[v][15:8], en = VEC[v][7:0];
      automatic logic [DW-1:0] t = 4 * v + 1, s0 = src_val;
      automatic int bad = 0, got;
      automatic logic [7:0] mv = dir[0] ? wr : rd, mvn = 8'((mv + en) % sz);
      for (int k = 0; k < 16; k++) mem[BASE + k] = 32'hB000 + 16 * v + k;
      mem[LOCK] = t; mem[TICK] = t;
      mem[DESC] = rd; mem[DESC + 1] = wr; mem[DESC + 2] = ct;
      cop_level_i = LW'(lv);
      cfg(3'd0, DW'(dir)); cfg(3'd2, DW'(sz));
      sink_n = 0; log_n = 0; log_on = (v == 0);
      one_pass();
      log_on = 0;
      got = dir[0] ? int'(src_val - s0) : sink_n;
      chk(got == int'(en), $sformatf("R7 burst length vec%0d", v), got, en);
      chk(mem[DESC] == (dir[0] ? rd : mvn) && mem[DESC + 1] == (dir[0] ? mvn : wr),
          $sformatf("R6 indices vec%0d", v), {mem[DESC][15:0], mem[DESC + 1][15:0]},
          {8'h0, dir[0] ? rd : mvn, 8'h0, dir[0] ? mvn : wr});
      chk(mem[DESC + 2] == (dir[0] ? ct + en : ct - en), $sformatf("R6 count vec%0d", v),
          mem[DESC + 2], dir[0] ? ct + en : ct - en);
      for (int i = 0; i < int'(en); i++) begin
        automatic logic [7:0] p = 8'((mv + i) % sz);
        if (dir[0] && mem[BASE + p] != s0 + i) bad++;
        if (!dir[0] && (i >= sink_n || sink[i] != 32'hB000 + 16 * v + p)) bad++;
      end
      chk(bad == 0, dir[0] ? "R8 producer data" : "R9 consumer data", bad, 0);
      chk(mem[LOCK] == t + 1 && mem[TICK] == t + 1, "R10 release ticket+1", mem[LOCK], t + 1);
      if (v == 0) begin
        automatic logic [1:0] ec [13] = '{0, 2, 0, 0, 1, 1, 1, 1, 1, 1, 1, 1, 1};
        automatic logic [7:0] ea [13] = '{TICK, TICK, LOCK, DESC, BASE, BASE + 1, BASE + 2,
                                          BASE + 3, BASE + 4, DESC, DESC + 1, DESC + 2, LOCK};
        automatic int sb = (log_n == 13) ? 0 : 1;
        for (int i = 0; i < 13 && i < log_n; i++)
          if (log_cmd[i] != ec[i] || log_addr[i] != ea[i]) sb++;
        chk(sb == 0, "R3 step order", log_n, 13);
      end
    end

    // stream across buffer wrap: producer then consumer, looping
    begin
      automatic logic [DW-1:0] s0 = src_val;
      automatic int bad = 0;
      mem[LOCK] = 40; mem[TICK] = 40;
      mem[DESC] = 6; mem[DESC + 1] = 6; mem[DESC + 2] = 0;
      cop_level_i = 5;
      cfg(3'd0, 1); cfg(3'd2, 8);
      cfg(3'd5, 1); wait_cyc(600); cfg(3'd5, 0); wait_cyc(300);
      chk(src_val - s0 == 8 && mem[DESC + 2] == 8 && mem[DESC + 1] == 6, "R8 fill across wrap",
          src_val - s0, 8);
      sink_n = 0; cop_level_i = 3;
      cfg(3'd0, 0);
      cfg(3'd5, 1); wait_cyc(600); cfg(3'd5, 0); wait_cyc(300);
      for (int k = 0; k < 8; k++) if (k >= sink_n || sink[k] != s0 + k) bad++;
      chk(bad == 0 && sink_n == 8, "R9 stream order across wrap", sink_n, 8);
      chk(mem[DESC] == 6 && mem[DESC + 2] == 0, "R10 loop drained buffer", mem[DESC + 2], 0);
    end

    // lock contention: spin until lock serves our ticket
    mem[LOCK] = 18; mem[TICK] = 20;
    mem[DESC] = 0; mem[DESC + 1] = 0; mem[DESC + 2] = 8;
    cfg(3'd0, 1);
    cfg(3'd5, 1); cfg(3'd5, 0);
    wait_cyc(100);
    chk(mem[TICK] == 21, "R4 ticket taken", mem[TICK], 21);
    chk(mem[LOCK] == 18 && mem[DESC + 2] == 8 && !irq_o, "R5 spin holds", mem[LOCK], 18);
    mem[LOCK] = 20;
    wait_cyc(200);
    chk(mem[LOCK] == 21, "R5 proceeds after lock turn", mem[LOCK], 21);

    // ticket stolen during compare-and-swap
    begin
      automatic int c0 = n_cas;
      mem[LOCK] = 31; mem[TICK] = 30; cas_steal = 1;
      one_pass();
      chk(n_cas - c0 == 2, "R4 swap retried", n_cas - c0, 2);
      chk(mem[TICK] == 32 && mem[LOCK] == 32, "R4 second ticket used", mem[LOCK], 32);
    end

    // bus error on descriptor word 1
    begin
      automatic int a0;
      mem[LOCK] = 44; mem[TICK] = 44;
      err_addr = {1'b0, DESC + 8'd1};
      cfg(3'd5, 1);
      wait_cyc(100);
      chk(irq_o == 1'b1, "R11 irq on error", irq_o, 1);
      a0 = n_acc;
      wait_cyc(50);
      chk(n_acc == a0 && irq_o, "R11 no requests in error", n_acc - a0, 0);
      err_addr = 9'h1FF;
      cfg(3'd5, 0);
      wait_cyc(2); #1;
      chk(irq_o == 1'b0, "R11 cleared by running=0", irq_o, 0);
      mem[LOCK] = 50; mem[TICK] = 50;
      one_pass();
      chk(mem[LOCK] == 51 && !irq_o, "R11 recovers after clear", mem[LOCK], 51);
    end

    chk(hold_viol == 0, "R12 request held while stalled", hold_viol, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule